// File: doc/BRIEF.md
# Strobed Input Handshake Channel

This block is one handshaked input channel of a parallel peripheral port. An external device places a byte on its data lines and pulls an active-low strobe. The channel then holds that byte in an input latch. It raises a buffer-full flag back to the device, which must not send again until the flag drops. Once the strobe has returned high, and only if the channel's interrupt-enable bit is set, the channel requests an interrupt from the processor.

The processor takes the byte with a read pulse. The start of the pulse withdraws the interrupt request, and the end of the pulse frees the buffer. The interrupt-enable bit has no address of its own. It is written through the port's single-bit set/reset command, which names one port line. Channel A owns line 4 and channel B owns line 2. A status byte places the interrupt request, the strobe level and the buffer-full flag on the port bit positions assigned to the channel, so software can poll instead of taking interrupts.

A parameter selects whether the instance is channel A or channel B. The choice sets the set/reset line that the channel responds to and the layout of its status bits. Address decoding and the mode register belong to the surrounding port and are not part of this block.

Top module: `strobed_input_channel`

## Requirements
- R1: After synchronous reset (active-low `rst_n`), `buf_full` is 0, `irq` is 0 and interrupt enable is 0. With interrupt enable still at its reset value, a completed transfer raises no `irq`.
- R2: The strobe passes through a two-flop synchronizer before its falling edge is detected. When `dev_stb_n` falls while `buf_full` is 0, the channel captures `dev_data`. `buf_full` rises on the third rising clock edge after the fall and stays 0 before that. `cpu_rdata` presents the captured byte.
- R3: A strobe that arrives while `buf_full` is 1 is ignored. `cpu_rdata` keeps the held byte and `buf_full` stays 1.
- R4: `irq` never rises while the capturing strobe is still low. With interrupt enable at 1, `irq` rises on the third rising clock edge after `dev_stb_n` returns high, and not before.
- R5: With interrupt enable at 0, a full buffer raises no `irq`. Setting interrupt enable later, while the buffer is full and the strobe has ended, raises `irq` on the edge that performs the write.
- R6: The rising edge of `cpu_rd` clears `irq` on the next clock edge. `buf_full` stays 1 while `cpu_rd` is held high and clears on the first clock edge after `cpu_rd` falls.
- R7: A set/reset command (`bsr_wr` high for one cycle) loads `bsr_val` into interrupt enable only when `bsr_sel` equals the channel's own line: 4 for channel A, 2 for channel B. A command naming any other line leaves interrupt enable unchanged.
- R8: The status byte carries the bits below. All other bits are 0. The strobe bit shows the synchronized level of `dev_stb_n`, so it reads 1 when the strobe is idle.
  - Channel A: `irq` on bit 3, strobe level on bit 4, `buf_full` on bit 5.
  - Channel B: `irq` on bit 0, `buf_full` on bit 1, strobe level on bit 2.
- R9: After a read completes, the next strobe captures a new byte, and the full handshake repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dev_data | input | DATA_W | Byte presented by the external device |
| dev_stb_n | input | 1 | Active-low strobe from the device (asynchronous) |
| buf_full | output | 1 | Input buffer full, back to the device |
| cpu_rd | input | 1 | Processor read pulse, high for the duration of the read |
| cpu_rdata | output | DATA_W | Byte held in the input latch |
| bsr_wr | input | 1 | Single-bit set/reset command strobe |
| bsr_sel | input | 3 | Port line named by the set/reset command |
| bsr_val | input | 1 | Value written by the set/reset command |
| irq | output | 1 | Interrupt request to the processor |
| status | output | 8 | Pollable status byte |

## Verification
The assertions assume the device follows the handshake. It keeps `dev_data` stable from the strobe's fall until the strobe returns high, it holds each strobe level for at least three clocks, and it does not start a read and a strobe capture in the same cycle. They also assume `cpu_rd` is a clean level pulse lasting at least one clock. The stimulus drives every input on the falling clock edge and holds each strobe level for several cycles. It starts reads only after the strobe has settled high, so every edge the synchronizer sees is clean.

// File: rtl/strb_in_pkg.sv
// Shared definitions for the strobed input channel.
// Assumes: the status byte is 8 bits wide and set/reset commands name
// one of 8 port lines. The functions map a channel to its bit positions.
package strb_in_pkg;

    typedef enum logic {
        CHAN_A = 1'b0,
        CHAN_B = 1'b1
    } chan_e;

    localparam int STATUS_W = 8;
    localparam int LINE_W   = 3;

    // Status bit carrying the interrupt request
    function automatic int irq_bit(chan_e ch);
        return (ch == CHAN_A) ? 3 : 0;
    endfunction

    // Status bit carrying the synchronized strobe level
    function automatic int stb_bit(chan_e ch);
        return (ch == CHAN_A) ? 4 : 2;
    endfunction

    // Status bit carrying the buffer-full flag
    function automatic int full_bit(chan_e ch);
        return (ch == CHAN_A) ? 5 : 1;
    endfunction

    // Port line whose set/reset command writes interrupt enable
    function automatic int inte_line(chan_e ch);
        return (ch == CHAN_A) ? 4 : 2;
    endfunction

endpackage

// File: rtl/strb_sync.sv
// Strobe synchronizer and edge detector.
// Brings the asynchronous active-low strobe into the clock domain through
// STAGES flops, then flags falling and rising edges of the synchronized
// level for one cycle each.
// Assumes: STAGES >= 2 and the strobe holds each level for several clocks.
module strb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic level,
    output logic fell,
    output logic rose
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Synchronizer chain; each stage is one flop, reset to idle (high)
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b1;
                else        chain[g] <= async_n;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b1;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign level = chain[STAGES-1];

    // Remember the previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= level;
    end

    assign fell = prev & ~level;
    assign rose = ~prev & level;

    // R2: an edge flag never lasts two cycles in a row
    assert_edge_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fell |=> !fell);

endmodule

// File: rtl/strb_inte_reg.sv
// Interrupt-enable bit of one channel.
// Loads the value of a single-bit set/reset command when the command names
// this channel's own port line, and ignores commands for other lines.
// Assumes: bsr_wr is a one-cycle command strobe.
module strb_inte_reg #(
    parameter int LINE_W = 3,
    parameter int LINE   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [LINE_W-1:0] sel,
    input  logic              value,
    output logic              inte
);
    localparam logic [LINE_W-1:0] OWN_LINE = LINE_W'(LINE);

    logic hit;
    assign hit = wr && (sel == OWN_LINE);

    // Hold interrupt enable; update only on a command to the own line
    always_ff @(posedge clk) begin
        if (!rst_n)   inte <= 1'b0;
        else if (hit) inte <= value;
    end

    // R7: interrupt enable changes only after a command naming its own line
    assert_inte_own_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inte != $past(inte)) |-> $past(wr && (sel == OWN_LINE)));

endmodule

// File: rtl/strb_core.sv
// Handshake core of the input channel.
// Captures the byte on a synchronized strobe fall when the buffer is empty,
// waits for the strobe to return high before arming the interrupt, clears
// the request on the start of a processor read and frees the buffer when
// the read ends.
// Assumes: data_in is stable while the strobe is low and the read is a
// level pulse of at least one clock.
module strb_core #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_in,
    input  logic              stb_fell,
    input  logic              stb_rose,
    input  logic              rd,
    input  logic              inte,
    output logic              full,
    output logic              irq,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] latch_q;
    logic              rd_prev;
    logic              wait_rise;
    logic              armed;
    logic              rd_start;
    logic              rd_end;
    logic              capture;

    assign rd_start = rd & ~rd_prev;
    assign rd_end   = ~rd & rd_prev;
    assign capture  = stb_fell & ~full;

    // Track the previous read level for start/end detection
    always_ff @(posedge clk) begin
        if (!rst_n) rd_prev <= 1'b0;
        else        rd_prev <= rd;
    end

    // Input latch and buffer-full flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            full    <= 1'b0;
        end else if (capture) begin
            latch_q <= data_in;
            full    <= 1'b1;
        end else if (rd_end) begin
            full    <= 1'b0;
        end
    end

    // Interrupt arming: wait for the capturing strobe to end, drop on read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_rise <= 1'b0;
            armed     <= 1'b0;
        end else begin
            if (rd_start) begin
                wait_rise <= 1'b0;
                armed     <= 1'b0;
            end else if (stb_rose && wait_rise) begin
                wait_rise <= 1'b0;
                armed     <= 1'b1;
            end
            if (capture) begin
                wait_rise <= 1'b1;
                armed     <= 1'b0;
            end
        end
    end

    assign irq   = armed & inte & full;
    assign rdata = latch_q;

    // R2: the buffer only fills on a detected strobe fall
    assert_fill_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> $past(stb_fell));

    // R3: a held byte is never overwritten while the buffer stays full
    assert_hold_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> $stable(latch_q));

    // R4: the request never appears in the cycle the buffer fills
    assert_no_early_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> !irq);

    // R6: the start of a read withdraws the request on the next edge
    assert_read_clears_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> !irq);

    // R6: the buffer only empties after a read has ended
    assert_free_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full) |-> $past(rd_end));

endmodule

// File: rtl/strb_status_map.sv
// Status byte formatter.
// Places the interrupt request, strobe level and buffer-full flag on the
// bit positions assigned to the selected channel; spare bits read 0.
// Assumes: the three positions for a channel are distinct.
module strb_status_map
    import strb_in_pkg::*;
#(
    parameter chan_e CHANNEL = CHAN_A
) (
    input  logic                irq,
    input  logic                stb_level,
    input  logic                full,
    output logic [STATUS_W-1:0] status
);
    localparam int IRQ_POS  = irq_bit(CHANNEL);
    localparam int STB_POS  = stb_bit(CHANNEL);
    localparam int FULL_POS = full_bit(CHANNEL);

    // Assemble the status byte for this channel
    always_comb begin
        status           = '0;
        status[IRQ_POS]  = irq;
        status[STB_POS]  = stb_level;
        status[FULL_POS] = full;
    end

endmodule

// File: rtl/strobed_input_channel.sv
// Strobed input handshake channel (top).
// Ties together the strobe synchronizer, the interrupt-enable register,
// the handshake core and the status formatter for channel A or B.
// Assumes: bus decoding and mode selection live outside this block.
module strobed_input_channel
    import strb_in_pkg::*;
#(
    parameter chan_e CHANNEL     = CHAN_A,
    parameter int    DATA_W      = 8,
    parameter int    SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DATA_W-1:0]   dev_data,
    input  logic                dev_stb_n,
    output logic                buf_full,
    input  logic                cpu_rd,
    output logic [DATA_W-1:0]   cpu_rdata,
    input  logic                bsr_wr,
    input  logic [LINE_W-1:0]   bsr_sel,
    input  logic                bsr_val,
    output logic                irq,
    output logic [STATUS_W-1:0] status
);
    localparam int OWN_LINE = inte_line(CHANNEL);

    logic stb_level;
    logic stb_fell;
    logic stb_rose;
    logic inte;

    strb_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_n (dev_stb_n),
        .level   (stb_level),
        .fell    (stb_fell),
        .rose    (stb_rose)
    );

    strb_inte_reg #(
        .LINE_W (LINE_W),
        .LINE   (OWN_LINE)
    ) u_inte (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bsr_wr),
        .sel   (bsr_sel),
        .value (bsr_val),
        .inte  (inte)
    );

    strb_core #(
        .DATA_W (DATA_W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_in  (dev_data),
        .stb_fell (stb_fell),
        .stb_rose (stb_rose),
        .rd       (cpu_rd),
        .inte     (inte),
        .full     (buf_full),
        .irq      (irq),
        .rdata    (cpu_rdata)
    );

    strb_status_map #(
        .CHANNEL (CHANNEL)
    ) u_status (
        .irq       (irq),
        .stb_level (stb_level),
        .full      (buf_full),
        .status    (status)
    );

    // R1: a disabled channel never requests an interrupt
    assert_irq_needs_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> inte);

endmodule

// File: tb/test_strobed_input_channel.sv
// Directed bench: one task per scenario, inputs driven and outputs sampled
// on the falling clock edge.
module test_strobed_input_channel;
    import strb_in_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] dev_data = 8'h00;
    logic       dev_stb_n = 1'b1;
    logic       cpu_rd = 1'b0;
    logic       bsr_wr = 1'b0;
    logic [2:0] bsr_sel = 3'd0;
    logic       bsr_val = 1'b0;

    logic       full_a, irq_a, full_b, irq_b;
    logic [7:0] rdata_a, rdata_b, status_a, status_b;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strobed_input_channel #(.CHANNEL(CHAN_A)) i_strobed_input_channel (
        .clk(clk), .rst_n(rst_n), .dev_data(dev_data), .dev_stb_n(dev_stb_n),
        .buf_full(full_a), .cpu_rd(cpu_rd), .cpu_rdata(rdata_a),
        .bsr_wr(bsr_wr), .bsr_sel(bsr_sel), .bsr_val(bsr_val),
        .irq(irq_a), .status(status_a)
    );

    strobed_input_channel #(.CHANNEL(CHAN_B)) i_strobed_input_channel_b (
        .clk(clk), .rst_n(rst_n), .dev_data(dev_data), .dev_stb_n(dev_stb_n),
        .buf_full(full_b), .cpu_rd(cpu_rd), .cpu_rdata(rdata_b),
        .bsr_wr(bsr_wr), .bsr_sel(bsr_sel), .bsr_val(bsr_val),
        .irq(irq_b), .status(status_b)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bsr(input logic [2:0] line, input logic val);
        bsr_sel = line; bsr_val = val; bsr_wr = 1'b1;
        step(1);
        bsr_wr = 1'b0;
    endtask

    task automatic read_byte();
        cpu_rd = 1'b1;
        step(3);
        cpu_rd = 1'b0;
        step(1);
    endtask

    // R1, R8: state right after reset
    task automatic t_reset();
        chk("R1 buf_full", full_a, 0);
        chk("R1 irq", irq_a, 0);
        chk("R8 status A idle", status_a, 8'h10);
        chk("R8 status B idle", status_b, 8'h04);
    endtask

    // R2, R8, R1, R7, R5, R3, R6: first transfer with enable set late
    task automatic t_first_transfer();
        dev_data = 8'hA5; dev_stb_n = 1'b0;
        step(2);
        chk("R2 not full before third edge", full_a, 0);
        step(1);
        chk("R2 full on third edge", full_a, 1);
        chk("R2 byte captured", rdata_a, 8'hA5);
        chk("R8 status A strobing", status_a, 8'h20);
        dev_stb_n = 1'b1;
        step(5);
        chk("R1 no irq with reset enable", irq_a, 0);
        bsr(3'd2, 1'b1);
        chk("R7 other line ignored", irq_a, 0);
        chk("R8 status A full", status_a, 8'h30);
        chk("R8 status B irq", status_b, 8'h07);
        bsr(3'd4, 1'b1);
        chk("R5 late enable raises irq", irq_a, 1);
        chk("R8 status A irq", status_a, 8'h38);
        dev_data = 8'h3C; dev_stb_n = 1'b0;
        step(4);
        dev_stb_n = 1'b1;
        step(5);
        chk("R3 byte kept", rdata_a, 8'hA5);
        chk("R3 still full", full_a, 1);
        cpu_rd = 1'b1;
        step(1);
        chk("R6 irq cleared at read start", irq_a, 0);
        step(2);
        chk("R6 full held during read", full_a, 1);
        cpu_rd = 1'b0;
        step(1);
        chk("R6 full cleared after read", full_a, 0);
    endtask

    // R4, R9: interrupt timing on a second transfer
    task automatic t_irq_timing();
        dev_data = 8'h5A; dev_stb_n = 1'b0;
        step(5);
        chk("R9 second byte accepted", full_a, 1);
        chk("R4 no irq while strobe low", irq_a, 0);
        dev_stb_n = 1'b1;
        step(2);
        chk("R4 no irq before third edge", irq_a, 0);
        step(1);
        chk("R4 irq on third edge", irq_a, 1);
        chk("R9 second byte value", rdata_a, 8'h5A);
        read_byte();
        chk("R9 buffer free again", full_a, 0);
    endtask

    // R5, R7: disabled channel, then enable while full
    task automatic t_disabled();
        bsr(3'd4, 1'b0);
        dev_data = 8'hC3; dev_stb_n = 1'b0;
        step(4);
        dev_stb_n = 1'b1;
        step(6);
        chk("R5 no irq when disabled", irq_a, 0);
        chk("R5 full while disabled", full_a, 1);
        bsr(3'd5, 1'b1);
        chk("R7 line 5 ignored", irq_a, 0);
        bsr(3'd4, 1'b1);
        chk("R5 enable while full raises irq", irq_a, 1);
        read_byte();
        chk("R6 empty after read", full_a, 0);
    endtask

    initial begin
        step(4);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_first_transfer();
        t_irq_timing();
        t_disabled();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule